// File: doc/BRIEF.md
# Composite Sync and Blanking Generator

This block sits between a video timing controller and the monitor output. The controller's sync strobes are active high and can be programmed to any width. The block turns them into fixed-shape monitor pulses. It also produces a force-black flag that holds the picture dark around the vertical retrace. All of this work runs on a character-clock enable.

Two small counters do the work:

- **Horizontal counter.** It counts the characters during which controller HSYNC is high. The internal horizontal pulse covers counts 2 through 5, no matter how wide the programmed pulse is.
- **Vertical counter.** It counts HSYNC falling edges from the start of a vertical sync. The internal vertical pulse covers counts 2 through 5. Force-black is held until the 26th line has ended.

A pending graphics-mode request is applied at the character where the horizontal pulse starts. Composite sync is the XOR of the two internal pulses. A parameter chooses between two variants:

- **Legacy variant:** the vertical pulse always runs to the end of its window.
- **Gated variant:** the vertical pulse is cut off as soon as controller VSYNC goes low.

Top module: `csync_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears both counters, the pending request, and the `hsync_out`, `vsync_out`, `csync_out` and `black_out` outputs, and sets `mode_out` to 0.
- R2: On a clock edge where `ce` is low, no output changes, whatever the other inputs do.
- R3: The horizontal counter is set to 1 on the first enabled character where `hsync_in` is high and advances by one on each later enabled character with `hsync_in` high. `hsync_out` is high only after characters where the counter is 2 to 5. So if HSYNC first goes high at character N, `hsync_out` is high during characters N+2 to N+5.
- R4: `hsync_out` goes low after the first enabled character where `hsync_in` is low, even if the pulse is shorter than 6 characters.
- R5: The horizontal counter saturates at 15 and does not wrap. A controller HSYNC wider than 15 characters therefore produces one monitor pulse only.
- R6: A request (`mode_req_valid` high on an enabled character) is held pending. It is copied to `mode_out` on the edge where the horizontal counter reaches 2, which is the same edge where `hsync_out` rises, and at no other time. A newer request replaces an older one that is still pending.
- R7: A rising edge of `vsync_in` clears the vertical counter and starts a vertical period. During the period, each `hsync_in` falling edge seen on an enabled character adds one to the counter.
- R8: `vsync_out` is high only while the vertical counter is between 2 and 5 within an active period. In the legacy variant it rises after the second HSYNC falling edge and falls after the sixth.
- R9: `black_out` rises with the `vsync_in` rising edge. It stays high, even if `vsync_in` is short, until the 26th HSYNC falling edge, then clears.
- R10: In the gated variant, `vsync_out` is additionally forced low on any enabled character where `vsync_in` is low. In the legacy variant, the vertical window completes on its own.
- R11: `csync_out` always equals `hsync_out` XOR `vsync_out`, and it is registered on the same edge as both.
- R12: With controller HSYNC starting at character 46 and lasting 14 characters, `hsync_out` is high for characters 48 to 51 inclusive and for no other character of the line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-domain clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Character-clock enable; all state advances only when high |
| hsync_in | input | 1 | Controller horizontal sync, 1 = active |
| vsync_in | input | 1 | Controller vertical sync, 1 = active |
| mode_req_valid | input | 1 | A new graphics mode is requested this character |
| mode_req | input | MODE_W | Requested graphics mode |
| hsync_out | output | 1 | Re-timed horizontal sync |
| vsync_out | output | 1 | Re-timed vertical sync |
| csync_out | output | 1 | Composite sync (XOR of the two re-timed syncs) |
| mode_out | output | MODE_W | Graphics mode currently applied |
| black_out | output | 1 | Force-black flag for the retrace period |

## Verification
The in-design properties are checked on every cycle. They cover:

- outputs holding while the enable is low;
- the horizontal and vertical pulses staying inside their counter windows;
- the horizontal counter saturating and restarting;
- mode changes happening only on a rising horizontal pulse;
- force-black ending only at the 26th line;
- composite sync matching the XOR;
- in the gated variant, no vertical pulse without controller VSYNC.

Some behaviour can only be shown by the bench's scenarios, which drive a legacy and a gated copy side by side. That covers:

- the exact character positions of the pulse for the worked example;
- the absence of a second pulse under an over-long HSYNC;
- the cut-off versus self-completing vertical pulse after a two-line VSYNC;
- the 26-line blanking length.

// File: rtl/csync_gen_pkg.sv
package csync_gen_pkg;

   // Vertical pulse behaviour selected per instance
   typedef enum logic {
      TIMING_LEGACY = 1'b0,   // vertical window runs to completion
      TIMING_GATED  = 1'b1    // vertical window masked by controller VSYNC
   } vs_timing_e;

   // Bits needed to hold the value maxval
   function automatic int cnt_width(input int maxval);
      return $clog2(maxval + 1);
   endfunction

endpackage

// File: rtl/csg_hsync_shaper.sv
module csg_hsync_shaper #(
   parameter int HCNT_W = 4,
   parameter int H_ON   = 2,
   parameter int H_OFF  = 6
) (
   input  logic clk,
   input  logic rst,
   input  logic ce,
   input  logic hsync_in,
   output logic hs_q,
   output logic hs_n,
   output logic hfall,
   output logic commit
);

   localparam logic [HCNT_W-1:0] HMAX = {HCNT_W{1'b1}};
   localparam logic [HCNT_W-1:0] HON  = HCNT_W'(H_ON);
   localparam logic [HCNT_W-1:0] HOFF = HCNT_W'(H_OFF);

   initial begin
      if (H_ON < 1 || H_OFF <= H_ON || H_OFF > (2 ** HCNT_W) - 1)
         $fatal(1, "csg_hsync_shaper: window %0d..%0d does not fit %0d bits", H_ON, H_OFF, HCNT_W);
   end

   logic              hsync_d;
   logic              hrise;
   logic              hfall_c;
   logic [HCNT_W-1:0] hcnt_q;
   logic [HCNT_W-1:0] hcnt_n;

   always_comb begin
      hrise   = hsync_in & ~hsync_d;
      hfall_c = ~hsync_in & hsync_d;
      hcnt_n  = hcnt_q;
      if (hsync_in) begin
         if (hrise)
            hcnt_n = HCNT_W'(1);
         else if (hcnt_q != HMAX)
            hcnt_n = hcnt_q + 1'b1;
      end
      hs_n   = hsync_in && (hcnt_n >= HON) && (hcnt_n < HOFF);
      commit = ce && hsync_in && (hcnt_n == HON);
      hfall  = ce && hfall_c;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         hsync_d <= 1'b0;
         hcnt_q  <= '0;
         hs_q    <= 1'b0;
      end else if (ce) begin
         hsync_d <= hsync_in;
         hcnt_q  <= hcnt_n;
         hs_q    <= hs_n;
      end
   end

   // R3: the pulse never leaves its counter window
   p_hs_window_r3 : assert property (@(posedge clk) disable iff (rst)
      hs_q |-> (hcnt_q >= HON && hcnt_q < HOFF));

   // R4: a freshly updated pulse needs controller HSYNC on that character
   p_hs_needs_hsync_r4 : assert property (@(posedge clk) disable iff (rst)
      (hs_q && $past(ce)) |-> $past(hsync_in));

   // R5: saturation instead of wrap
   p_hcnt_sat_r5 : assert property (@(posedge clk) disable iff (rst)
      (ce && hsync_in && hsync_d && hcnt_q == HMAX) |=> (hcnt_q == HMAX));

   // R5: restart at the controller rising edge
   p_hcnt_restart_r5 : assert property (@(posedge clk) disable iff (rst)
      (ce && hsync_in && !hsync_d) |=> (hcnt_q == HCNT_W'(1)));

endmodule

// File: rtl/csg_vsync_shaper.sv
module csg_vsync_shaper #(
   parameter int LINES = 26,
   parameter int V_ON  = 2,
   parameter int V_OFF = 6,
   parameter csync_gen_pkg::vs_timing_e TIMING = csync_gen_pkg::TIMING_LEGACY
) (
   input  logic clk,
   input  logic rst,
   input  logic ce,
   input  logic vsync_in,
   input  logic hfall,
   output logic vs_q,
   output logic vs_n,
   output logic black_q
);

   localparam int VCNT_W = csync_gen_pkg::cnt_width(LINES);
   localparam logic [VCNT_W-1:0] VON   = VCNT_W'(V_ON);
   localparam logic [VCNT_W-1:0] VOFF  = VCNT_W'(V_OFF);
   localparam logic [VCNT_W-1:0] VLAST = VCNT_W'(LINES);

   initial begin
      if (V_ON < 1 || V_OFF <= V_ON || V_OFF > LINES)
         $fatal(1, "csg_vsync_shaper: window %0d..%0d outside %0d lines", V_ON, V_OFF, LINES);
   end

   logic              vsync_d;
   logic              vrise;
   logic              gate;
   logic              active_q;
   logic              active_n;
   logic [VCNT_W-1:0] vcnt_q;
   logic [VCNT_W-1:0] vcnt_n;

   generate
      if (TIMING == csync_gen_pkg::TIMING_GATED) begin : g_gated
         assign gate = vsync_in;

         // R10: no freshly updated vertical pulse without controller VSYNC
         p_vs_gate_r10 : assert property (@(posedge clk) disable iff (rst)
            (vs_q && $past(ce)) |-> $past(vsync_in));
      end else begin : g_legacy
         assign gate = 1'b1;
      end
   endgenerate

   always_comb begin
      vrise    = vsync_in & ~vsync_d;
      vcnt_n   = vcnt_q;
      active_n = active_q;
      if (vrise) begin
         vcnt_n   = '0;
         active_n = 1'b1;
      end else if (active_q && hfall) begin
         vcnt_n = vcnt_q + 1'b1;
         if (vcnt_n == VLAST)
            active_n = 1'b0;
      end
      vs_n = active_n && gate && (vcnt_n >= VON) && (vcnt_n < VOFF);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         vsync_d  <= 1'b0;
         vcnt_q   <= '0;
         active_q <= 1'b0;
         vs_q     <= 1'b0;
      end else if (ce) begin
         vsync_d  <= vsync_in;
         vcnt_q   <= vcnt_n;
         active_q <= active_n;
         vs_q     <= vs_n;
      end
   end

   assign black_q = active_q;

   // R7: the line counter only restarts or steps by one
   p_vcnt_step_r7 : assert property (@(posedge clk) disable iff (rst)
      !$stable(vcnt_q) |-> (vcnt_q == '0 || vcnt_q == ($past(vcnt_q) + 1'b1)));

   // R8: the vertical pulse stays inside its line window
   p_vs_window_r8 : assert property (@(posedge clk) disable iff (rst)
      vs_q |-> (active_q && vcnt_q >= VON && vcnt_q < VOFF));

   // R9: blanking ends only on the last counted line
   p_black_end_r9 : assert property (@(posedge clk) disable iff (rst)
      $fell(active_q) |-> (vcnt_q == VLAST));

endmodule

// File: rtl/csg_mode_latch.sv
module csg_mode_latch #(
   parameter int MODE_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ce,
   input  logic              commit,
   input  logic              req_valid,
   input  logic [MODE_W-1:0] req_mode,
   output logic [MODE_W-1:0] mode_q
);

   initial begin
      if (MODE_W < 1)
         $fatal(1, "csg_mode_latch: MODE_W must be positive");
   end

   logic              pend_q;
   logic [MODE_W-1:0] pend_mode_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q      <= 1'b0;
         pend_mode_q <= '0;
         mode_q      <= '0;
      end else begin
         if (commit && pend_q)
            mode_q <= pend_mode_q;
         if (ce) begin
            if (req_valid) begin
               pend_q      <= 1'b1;
               pend_mode_q <= req_mode;
            end else if (commit) begin
               pend_q <= 1'b0;
            end
         end
      end
   end

   // R6: a committed request without a replacement is consumed
   p_pend_clear_r6 : assert property (@(posedge clk) disable iff (rst)
      (commit && pend_q && !req_valid) |=> !pend_q);

endmodule

// File: rtl/csync_gen.sv
module csync_gen #(
   parameter int MODE_W = 2,
   parameter int HCNT_W = 4,
   parameter int H_ON   = 2,
   parameter int H_OFF  = 6,
   parameter int LINES  = 26,
   parameter int V_ON   = 2,
   parameter int V_OFF  = 6,
   parameter csync_gen_pkg::vs_timing_e TIMING = csync_gen_pkg::TIMING_LEGACY
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ce,
   input  logic              hsync_in,
   input  logic              vsync_in,
   input  logic              mode_req_valid,
   input  logic [MODE_W-1:0] mode_req,
   output logic              hsync_out,
   output logic              vsync_out,
   output logic              csync_out,
   output logic [MODE_W-1:0] mode_out,
   output logic              black_out
);

   logic hs_n;
   logic vs_n;
   logic hfall;
   logic commit;
   logic csync_q;

   csg_hsync_shaper #(
      .HCNT_W (HCNT_W),
      .H_ON   (H_ON),
      .H_OFF  (H_OFF)
   ) u_hshape (
      .clk      (clk),
      .rst      (rst),
      .ce       (ce),
      .hsync_in (hsync_in),
      .hs_q     (hsync_out),
      .hs_n     (hs_n),
      .hfall    (hfall),
      .commit   (commit)
   );

   csg_vsync_shaper #(
      .LINES  (LINES),
      .V_ON   (V_ON),
      .V_OFF  (V_OFF),
      .TIMING (TIMING)
   ) u_vshape (
      .clk      (clk),
      .rst      (rst),
      .ce       (ce),
      .vsync_in (vsync_in),
      .hfall    (hfall),
      .vs_q     (vsync_out),
      .vs_n     (vs_n),
      .black_q  (black_out)
   );

   csg_mode_latch #(
      .MODE_W (MODE_W)
   ) u_mode (
      .clk       (clk),
      .rst       (rst),
      .ce        (ce),
      .commit    (commit),
      .req_valid (mode_req_valid),
      .req_mode  (mode_req),
      .mode_q    (mode_out)
   );

   always_ff @(posedge clk) begin
      if (rst)
         csync_q <= 1'b0;
      else if (ce)
         csync_q <= hs_n ^ vs_n;
   end

   assign csync_out = csync_q;

   // R1: reset leaves every output cleared
   p_reset_clear_r1 : assert property (@(posedge clk)
      rst |=> (!hsync_out && !vsync_out && !csync_out && !black_out && mode_out == '0));

   // R2: nothing moves on an edge without the enable
   p_hold_r2 : assert property (@(posedge clk) disable iff (rst)
      !ce |=> ($stable(hsync_out) && $stable(vsync_out) && $stable(csync_out)
               && $stable(black_out) && $stable(mode_out)));

   // R6: mode changes only together with the horizontal pulse start
   p_mode_at_hs_r6 : assert property (@(posedge clk) disable iff (rst)
      !$stable(mode_out) |-> $rose(hsync_out));

   // R11: composite sync tracks the two separately registered pulses
   p_csync_xor_r11 : assert property (@(posedge clk) disable iff (rst)
      csync_out == (hsync_out ^ vsync_out));

endmodule

// File: tb/test_csync_gen.sv
module test_csync_gen;
   import csync_gen_pkg::*;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       ce = 1'b0;
   logic       hs_i = 1'b0;
   logic       vs_i = 1'b0;
   logic       mv = 1'b0;
   logic [1:0] mr = 2'b00;

   logic       l_hs, l_vs, l_cs, l_bk;
   logic [1:0] l_md;
   logic       g_hs, g_vs, g_cs, g_bk;
   logic [1:0] g_md;

   always #4 clk = ~clk;   // 125 MHz

   csync_gen i_csync_gen (
      .clk (clk), .rst (rst), .ce (ce), .hsync_in (hs_i), .vsync_in (vs_i),
      .mode_req_valid (mv), .mode_req (mr),
      .hsync_out (l_hs), .vsync_out (l_vs), .csync_out (l_cs),
      .mode_out (l_md), .black_out (l_bk)
   );

   csync_gen #(.TIMING (TIMING_GATED)) i_csync_gen_gated (
      .clk (clk), .rst (rst), .ce (ce), .hsync_in (hs_i), .vsync_in (vs_i),
      .mode_req_valid (mv), .mode_req (mr),
      .hsync_out (g_hs), .vsync_out (g_vs), .csync_out (g_cs),
      .mode_out (g_md), .black_out (g_bk)
   );

   int nchk = 0;
   int nerr = 0;
   bit finished = 1'b0;
   bit m_cmp = 1'b0;

   // behavioural reference
   int m_hc, m_vc, m_pm, e_md;
   bit m_va, m_hd, m_vd, m_pend, e_hs, e_vs, e_vsg;

   always @(posedge clk) begin
      if (rst) begin
         m_hc = 0; m_vc = 0; m_pm = 0; e_md = 0;
         m_va = 0; m_hd = 0; m_vd = 0; m_pend = 0;
         e_hs = 0; e_vs = 0; e_vsg = 0;
      end else if (ce) begin
         if (hs_i) begin
            if (!m_hd) m_hc = 1;
            else if (m_hc < 15) m_hc = m_hc + 1;
         end
         e_hs = hs_i && m_hc >= 2 && m_hc <= 5;
         if (hs_i && m_hc == 2 && m_pend) begin
            e_md = m_pm;
            m_pend = 0;
         end
         if (mv) begin
            m_pend = 1;
            m_pm = int'(mr);
         end
         if (vs_i && !m_vd) begin
            m_vc = 0;
            m_va = 1;
         end else if (m_va && m_hd && !hs_i) begin
            m_vc = m_vc + 1;
            if (m_vc == 26) m_va = 0;
         end
         e_vs  = m_va && m_vc >= 2 && m_vc <= 5;
         e_vsg = e_vs && vs_i;
         m_hd = hs_i;
         m_vd = vs_i;
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // per-clock comparison against the reference
   always @(negedge clk) begin
      if (m_cmp && !rst) begin
         chk("R3",  "legacy hsync", int'(l_hs), int'(e_hs));
         chk("R3",  "gated hsync",  int'(g_hs), int'(e_hs));
         chk("R8",  "legacy vsync", int'(l_vs), int'(e_vs));
         chk("R10", "gated vsync",  int'(g_vs), int'(e_vsg));
         chk("R11", "legacy csync", int'(l_cs), int'(e_hs ^ e_vs));
         chk("R11", "gated csync",  int'(g_cs), int'(e_hs ^ e_vsg));
         chk("R9",  "legacy black", int'(l_bk), int'(m_va));
         chk("R9",  "gated black",  int'(g_bk), int'(m_va));
         chk("R6",  "legacy mode",  int'(l_md), e_md);
         chk("R6",  "gated mode",   int'(g_md), e_md);
      end
   end

   bit        snap_ok = 1'b0;
   logic [5:0] snap;

   // one character: an enabled clock, then a disabled clock with scrambled inputs
   task automatic tick(input bit h, input bit v, input bit rv, input logic [1:0] rm);
      @(negedge clk);
      if (snap_ok)
         chk("R2", "outputs held across disabled edge",
             int'({l_hs, l_vs, l_cs, l_bk, l_md}), int'(snap));
      ce = 1'b1; hs_i = h; vs_i = v; mv = rv; mr = rm;
      @(negedge clk);
      ce = 1'b0; hs_i = ~h; vs_i = ~v; mv = 1'b1; mr = ~rm;
      snap = {l_hs, l_vs, l_cs, l_bk, l_md};
      snap_ok = 1'b1;
   endtask

   task automatic run_line(input int hstart, input int hwidth, input bit v,
                           input int req_at, input logic [1:0] req_mode, input bit worked);
      logic [1:0] old_md;
      old_md = l_md;
      for (int c = 0; c < 64; c++) begin
         bit h;
         h = (c >= hstart) && (c < hstart + hwidth);
         tick(h, v, c == req_at, req_mode);
         if (worked)  // R12: monitor pulse on characters 48..51 only
            chk("R12", "worked example hsync", int'(l_hs), int'(c >= 47 && c <= 50));
         if (req_at >= 0 && req_at < hstart) begin
            if (c == hstart)
               chk("R6", "mode held before pulse start", int'(l_md), int'(old_md));
            if (c == hstart + 1)
               chk("R6", "mode applied at pulse start", int'(l_md), int'(req_mode));
         end
         if (hwidth == 3 && c == hstart + 2)
            chk("R4", "short hsync pulse on", int'(l_hs), 1);
         if (hwidth == 3 && c == hstart + 3)
            chk("R4", "short hsync pulse ends with input", int'(l_hs), 0);
         if (hwidth > 16 && c == hstart + 20)
            chk("R5", "no second pulse on long hsync", int'(l_hs), 0);
      end
   endtask

   task automatic frame(input int vlines, input int total);
      for (int ln = 0; ln < total; ln++) begin
         run_line(46, 14, ln < vlines, -1, 2'b00, 1'b0);
         if (ln == 0) chk("R7", "one falling edge, no vsync yet", int'(l_vs), 0);
         if (ln == 1) chk("R7", "second falling edge starts vsync", int'(l_vs), 1);
         if (ln == 4) chk("R8", "vsync still on at count 5", int'(l_vs), 1);
         if (ln == 5) chk("R8", "vsync off at count 6", int'(l_vs), 0);
         if (ln == 2 && vlines == 2) begin
            chk("R10", "legacy vsync completes alone", int'(l_vs), 1);
            chk("R10", "gated vsync cut by input", int'(g_vs), 0);
         end
         if (ln == 24) chk("R9", "black held through line 25", int'(l_bk), 1);
         if (ln == 25) chk("R9", "black cleared after line 26", int'(l_bk), 0);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; ce = 1'b1; hs_i = 1'b1; vs_i = 1'b1; mv = 1'b1; mr = 2'b11;
      repeat (3) @(negedge clk);
      chk("R1", "reset outputs legacy", int'({l_hs, l_vs, l_cs, l_bk, l_md}), 0);
      chk("R1", "reset outputs gated",  int'({g_hs, g_vs, g_cs, g_bk, g_md}), 0);
      rst = 1'b0; ce = 1'b0; hs_i = 1'b0; vs_i = 1'b0; mv = 1'b0; mr = 2'b00;
      snap_ok = 1'b0;
   endtask

   initial begin
      do_reset();
      m_cmp = 1'b1;
      run_line(46, 14, 1'b0, -1, 2'b00, 1'b1);
      run_line(46, 14, 1'b0, 10, 2'b10, 1'b1);
      run_line(10, 3, 1'b0, -1, 2'b00, 1'b0);
      run_line(20, 25, 1'b0, 5, 2'b01, 1'b0);
      run_line(46, 14, 1'b0, -1, 2'b00, 1'b0);
      frame(2, 30);
      frame(8, 30);
      frame(2, 4);
      chk("R9", "black active before mid-frame reset", int'(l_bk), 1);
      do_reset();
      run_line(46, 14, 1'b0, 3, 2'b11, 1'b1);
      run_line(30, 6, 1'b0, -1, 2'b00, 1'b0);
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!finished) begin
         nerr++;
         $display("FAIL all watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", nchk, nerr);
         $finish;
      end
   end

endmodule